// File: doc/BRIEF.md
# Hundredths Stopwatch

This block counts elapsed time in hundredths of a second from 00.00 up to 99.99 s. It keeps the count as four BCD digits, seconds tens and ones followed by hundredths tens and ones. Two modulo-100 BCD stages form the count. The lower stage holds the hundredths and the upper stage holds the whole seconds.

A 100 Hz tick enable, made elsewhere from the system clock, moves the count forward while the stopwatch runs. One button pulse starts the count or pauses it. Another button pulse zeroes the count. Button inputs are single-cycle pulses that have already been debounced. The digit outputs are meant to drive a display multiplexer outside this block.

Top module: `hs_stopwatch`

## Requirements
- R1: After reset the stopwatch is paused and all four digits read 0.
- R2: While running, each cycle with `tick_i` high and no button pulse adds one hundredth. Each digit port carries a 4-bit BCD value from 0 to 9, and the hundredths ones digit wraps from 9 to 0 with a carry into the hundredths tens digit.
- R3: While paused, `tick_i` has no effect on the digits. With no tick and no button pulse, the digits stay unchanged.
- R4: The seconds digits change only on a tick that finds the hundredths at 99. On that tick the hundredths go to 00 and the seconds go up by one.
- R5: A `toggle_i` pulse without `clear_i` inverts `running_o` at the next clock edge. The one exception is stated in R8.
- R6: A `clear_i` pulse sets all digits to 0 and leaves the stopwatch paused. This holds whether the stopwatch was running or paused, and clear wins over a toggle or a tick in the same cycle.
- R7: The tick that brings the count to 99.99 also clears `running_o`. The count then holds at 99.99 and never wraps.
- R8: A `toggle_i` pulse while paused at 99.99 is ignored, so the stopwatch stays paused at 99.99.
- R9: When `toggle_i` and `tick_i` arrive in the same cycle, the toggle takes effect and that tick is dropped, so the digits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 100 Hz count enable, one cycle wide |
| toggle_i | input | 1 | Start/pause pulse |
| clear_i | input | 1 | Zero-the-count pulse |
| sec_tens_o | output | 4 | BCD tens of seconds |
| sec_ones_o | output | 4 | BCD ones of seconds |
| hun_tens_o | output | 4 | BCD tens of hundredths |
| hun_ones_o | output | 4 | BCD ones of hundredths |
| running_o | output | 1 | High while counting |

## Verification
The hardest state to reach from the ports is the ceiling at 99.99. Reaching it takes 9999 uninterrupted running ticks, and random stimulus with clears and pauses mixed in never gets there. A directed phase therefore clears the stopwatch, starts it, and applies a tick on every cycle until the count stops by itself. It then checks that further ticks and a start press leave 99.99 and the paused state unchanged. Random phases that follow cover same-cycle collisions among clear, toggle and tick against a behavioural reference model.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIGIT_W    = 4;
    localparam int NUM_STAGES = 2;
    localparam int DIGIT_MAX  = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t ones;
    } stage_t;

    typedef struct packed {
        logic                       running;
        stage_t [NUM_STAGES-1:0]    stage;
    } sw_state_t;
endpackage

// File: rtl/sw_bcd_stage.sv
module sw_bcd_stage
    import sw_pkg::*;
(
    input  stage_t cur_i,
    input  logic   inc_i,
    output stage_t nxt_o,
    output logic   at_max_o,
    output logic   nxt_max_o
);
    localparam bcd_t TOP = bcd_t'(DIGIT_MAX);

    always_comb begin
        nxt_o    = cur_i;
        at_max_o = (cur_i.tens == TOP) && (cur_i.ones == TOP);
        if (inc_i) begin
            if (cur_i.ones == TOP) begin
                nxt_o.ones = '0;
                nxt_o.tens = (cur_i.tens == TOP) ? '0 : bcd_t'(cur_i.tens + 1'b1);
            end else begin
                nxt_o.ones = bcd_t'(cur_i.ones + 1'b1);
            end
        end
        nxt_max_o = (nxt_o.tens == TOP) && (nxt_o.ones == TOP);
    end
endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl (
    input  logic running_i,
    input  logic tick_i,
    input  logic toggle_i,
    input  logic clear_i,
    input  logic full_now_i,
    input  logic full_next_i,
    output logic step_o,
    output logic zero_o,
    output logic running_o
);
    always_comb begin
        step_o    = 1'b0;
        zero_o    = 1'b0;
        running_o = running_i;
        if (clear_i) begin
            zero_o    = 1'b1;
            running_o = 1'b0;
        end else if (toggle_i) begin
            if (!(full_now_i && !running_i)) begin
                running_o = !running_i;
            end
        end else if (tick_i && running_i && !full_now_i) begin
            step_o = 1'b1;
            if (full_next_i) begin
                running_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/hs_stopwatch.sv
module hs_stopwatch
    import sw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               toggle_i,
    input  logic               clear_i,
    output logic [DIGIT_W-1:0] sec_tens_o,
    output logic [DIGIT_W-1:0] sec_ones_o,
    output logic [DIGIT_W-1:0] hun_tens_o,
    output logic [DIGIT_W-1:0] hun_ones_o,
    output logic               running_o
);
    sw_state_t state_q, state_d;

    logic [NUM_STAGES:0]   carry;
    logic [NUM_STAGES-1:0] at_max;
    logic [NUM_STAGES-1:0] nxt_max;
    stage_t [NUM_STAGES-1:0] stage_nxt;
    logic step, zero, run_nxt;

    assign carry[0] = step;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        sw_bcd_stage u_stage (
            .cur_i     (state_q.stage[i]),
            .inc_i     (carry[i]),
            .nxt_o     (stage_nxt[i]),
            .at_max_o  (at_max[i]),
            .nxt_max_o (nxt_max[i])
        );
        assign carry[i+1] = carry[i] & at_max[i];
    end

    sw_run_ctrl u_ctrl (
        .running_i   (state_q.running),
        .tick_i      (tick_i),
        .toggle_i    (toggle_i),
        .clear_i     (clear_i),
        .full_now_i  (&at_max),
        .full_next_i (&nxt_max),
        .step_o      (step),
        .zero_o      (zero),
        .running_o   (run_nxt)
    );

    always_comb begin
        state_d         = state_q;
        state_d.running = run_nxt;
        if (zero) begin
            state_d.stage = '0;
        end else begin
            state_d.stage = stage_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_tens_o = state_q.stage[1].tens;
    assign sec_ones_o = state_q.stage[1].ones;
    assign hun_tens_o = state_q.stage[0].tens;
    assign hun_ones_o = state_q.stage[0].ones;
    assign running_o  = state_q.running;
endmodule

// File: rtl/sw_checker.sv
module sw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       toggle_i,
    input logic       clear_i,
    input logic [3:0] sec_tens_o,
    input logic [3:0] sec_ones_o,
    input logic [3:0] hun_tens_o,
    input logic [3:0] hun_ones_o,
    input logic       running_o
);
    logic [15:0] val;
    logic [7:0]  lower;
    logic [7:0]  upper;
    assign val   = {sec_tens_o, sec_ones_o, hun_tens_o, hun_ones_o};
    assign lower = {hun_tens_o, hun_ones_o};
    assign upper = {sec_tens_o, sec_ones_o};

    p_digit_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tens_o <= 4'd9) && (sec_ones_o <= 4'd9) && (hun_tens_o <= 4'd9) && (hun_ones_o <= 4'd9));

    p_paused_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !clear_i) |=> $stable(val));

    p_upper_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && lower != 8'h99) |=> $stable(upper));

    p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_i && !clear_i && !(val == 16'h9999 && !running_o)) |=> (running_o != $past(running_o)));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (val == 16'h0000) && !running_o);

    p_ceiling_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (val == 16'h9999) |-> !running_o);

    p_ceiling_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (val == 16'h9999 && !running_o && !clear_i) |=> (val == 16'h9999) && !running_o);

    p_tick_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_i && tick_i && !clear_i) |=> $stable(val));
endmodule

bind hs_stopwatch sw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .toggle_i   (toggle_i),
    .clear_i    (clear_i),
    .sec_tens_o (sec_tens_o),
    .sec_ones_o (sec_ones_o),
    .hun_tens_o (hun_tens_o),
    .hun_ones_o (hun_ones_o),
    .running_o  (running_o)
);

// File: tb/hs_stopwatch_tb.sv
module hs_stopwatch_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, toggle_i = 1'b0, clear_i = 1'b0;
    logic [3:0] sec_tens_o, sec_ones_o, hun_tens_o, hun_ones_o;
    logic running_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_stopwatch u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .toggle_i(toggle_i), .clear_i(clear_i),
        .sec_tens_o(sec_tens_o), .sec_ones_o(sec_ones_o),
        .hun_tens_o(hun_tens_o), .hun_ones_o(hun_ones_o), .running_o(running_o)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    m_cnt = 0;
    bit    m_run = 1'b0;
    string m_tag = "R1";
    bit    finished = 1'b0;

    function automatic logic [15:0] to_bcd(int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic compare();
        logic [15:0] got, exp;
        got = {sec_tens_o, sec_ones_o, hun_tens_o, hun_ones_o};
        exp = to_bcd(m_cnt);
        vectors++;
        if (got !== exp || running_o !== m_run) begin
            miscompares++;
            $display("FAIL %s: digits=%h run=%b expected digits=%h run=%b",
                     m_tag, got, running_o, exp, m_run);
        end
    endtask

    // Reference model: priority clear, then toggle, then tick.
    task automatic model(bit t, bit g, bit c);
        if (c) begin
            m_cnt = 0; m_run = 1'b0; m_tag = "R6";
        end else if (g) begin
            if (m_cnt == 9999 && !m_run) m_tag = "R8";
            else begin
                m_run = !m_run;
                m_tag = t ? "R9" : "R5";
            end
        end else if (t && m_run) begin
            m_tag = ((m_cnt % 100) == 99) ? "R4" : "R2";
            m_cnt++;
            if (m_cnt == 9999) begin
                m_run = 1'b0; m_tag = "R7";
            end
        end else begin
            m_tag = (m_cnt == 9999) ? "R7" : "R3";
        end
    endtask

    task automatic step(bit t, bit g, bit c);
        @(negedge clk);
        compare();
        tick_i = t; toggle_i = g; clear_i = c;
        model(t, g, c);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state observed at first compare
        step(1, 0, 0);               // R3: tick while paused
        step(0, 1, 0);               // R5: start
        for (int i = 0; i < 250; i++) step(1, 0, 0);   // R2, R4 carries
        step(1, 1, 0);               // R9: pause with tick dropped
        step(1, 0, 0);
        step(1, 1, 0);               // R9: resume with tick dropped
        step(1, 0, 1);               // R6: clear while running
        step(0, 1, 1);               // R6: clear beats toggle
        // R7: run all the way to the ceiling
        step(0, 1, 0);
        for (int i = 0; i < 10010; i++) step(1, 0, 0);
        step(0, 1, 0);               // R8: start ignored at 99.99
        step(1, 1, 0);               // R8 with tick
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        step(0, 0, 1);               // R6: clear from ceiling
        // random mix
        for (int i = 0; i < 40000; i++) begin
            int r;
            r = $urandom_range(0, 999);
            step(r % 3 != 0, r < 20, r >= 995);
        end
        step(0, 0, 0);
        @(negedge clk);
        compare();
        summary();
    end
endmodule